// File: doc/BRIEF.md
# Burst ROM Read Controller

This block runs the external-bus side of a line fill from a read-only memory that supports burst access. An internal requester presents a start address together with the bus configuration: an interface-type code, a bus width, a burst-length code, a wait-cycle count and setup and hold counts. The controller fetches one 32-byte line, starting with the bus unit that holds the requested byte and wrapping within the 32-byte-aligned block. It packs the returned bytes into a line register and raises a one-cycle completion pulse.

In burst mode, chip select and the read strobe stay low from the first beat of a burst to its last, and only the address steps between beats. A line that needs more beats than one burst allows is split into back-to-back bursts, and the bus stays owned for the whole line. With any other interface type, each beat is a separate SRAM-style access. A write is always a single SRAM-style cycle, even when the burst type is selected.

Top module: `brom_ctrl`

## Requirements
- R1: After reset, chip select, read strobe and write strobe are high (inactive), and busy, line_valid and wr_done are low.
- R2: A read uses burst sequencing only when cfg_type equals 3'b010. With any other type, every beat is a separate access, and the read strobe rises after each beat.
- R3: Width codes are 0 for 8-bit, 1 for 16-bit, and 2 or 3 for 32-bit. Length codes 0, 1, 2 and 3 give bursts of 4, 8, 16 and 32 beats. The largest legal code is 3 for 8-bit, 2 for 16-bit and 1 for 32-bit, and any larger code is clamped to that largest legal code.
- R4: A line takes 32/B beats, where B is the bus width in bytes. The address of beat k is the 32-byte-aligned base plus ((start offset rounded down to B) + k·B) mod 32, and the upper address bits never change during a transfer.
- R5: Within one burst, chip select and the read strobe stay low and only the address changes. The read strobe rises exactly once per burst.
- R6: With W wait cycles configured, the first beat of each burst holds the strobe for 1+W cycles. Every later beat in the same burst takes 1+W cycles when W>0, and 3 cycles when W=0.
- R7: Each access or burst has S setup cycles before its strobe (chip select low, strobes high) and H hold cycles after its last strobe, and consecutive accesses are separated by one cycle with chip select high. A read takes G·(S + (1+W) + (L−1)·(W==0 ? 3 : 1+W) + H) + (G−1) busy cycles before line_valid, where L is the burst length (1 outside burst mode) and G = beats/L.
- R8: bus_rdy is sampled only in the last strobe cycle of a beat, and only when W>0. While it is low there, the beat is extended. With W=0, it has no effect.
- R9: busy is high from the cycle after a request is accepted until the completion pulse, gaps between bursts included. A req_valid that arrives while busy is ignored.
- R10: line_valid is a one-cycle pulse. On that cycle, byte b of line_data (bits 8b+7:8b) holds the byte read from address base+b, where byte j of bus_rdata (bits 8j+7:8j) belongs to the beat address plus j.
- R11: A write is one access of S + (1+W) + H cycles at req_addr. The write strobe is low for 1+W cycles, with req_wdata on bus_wdata. The read strobe stays high throughout, and wr_done pulses once at the end, whatever the interface type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_write | input | 1 | 1 = single write, 0 = line read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| cfg_type | input | 3 | Interface type, 3'b010 selects burst mode |
| cfg_width | input | 2 | Bus width code |
| cfg_len | input | 3 | Burst length code |
| cfg_wait | input | 4 | Wait cycles per strobe |
| cfg_setup | input | 2 | Setup cycles before a strobe |
| cfg_hold | input | 2 | Hold cycles after a strobe |
| bus_addr | output | 32 | Memory byte address of the current unit |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_wdata | output | 32 | Write data to memory |
| bus_rdy | input | 1 | Ready from memory |
| bus_rdata | input | 32 | Read data from memory |
| busy | output | 1 | Transfer in progress, bus held |
| line_valid | output | 1 | Line complete pulse |
| line_data | output | 256 | Assembled 32-byte line |
| wr_done | output | 1 | Write complete pulse |

## Verification
The bench starts bursts at unaligned offsets, so a design that fetched the aligned unit first, or let the offset carry into the upper address bits, produces a wrong beat address or a wrong line byte. It gives length codes above each width's maximum, where a missing clamp shows up as extra bursts or a count of read-strobe rises that does not match. It holds ready low with zero waits, where a design that sampled ready anyway would hang or stretch the cycle count. It holds ready low with waits set, where a design that ignored ready would move on to the next beat early. It also issues a stray request while busy, a write to a burst-type area, and a read with the SRAM type, to catch a restarted transfer, a write that bursts, and a strobe held low across separate accesses.

// File: rtl/brom_pkg.sv
package brom_pkg;

    localparam int unsigned BROM_AW    = 32;
    localparam int unsigned BROM_DW    = 32;
    localparam int unsigned WAIT_W     = 4;
    localparam int unsigned SH_W       = 2;
    localparam int unsigned LINE_BYTES = 32;
    localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
    localparam int unsigned BEAT_W     = OFF_W + 1;
    localparam int unsigned CNT_W      = WAIT_W + 1;
    localparam int unsigned LANE_W     = $clog2(BROM_DW / 8);

    localparam logic [2:0] IF_BURST = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STRB,
        ST_HOLD,
        ST_GAP,
        ST_DONE
    } brom_state_e;

    typedef struct packed {
        logic [BROM_AW-1:0] addr;
        logic [BROM_DW-1:0] wdata;
        logic               write;
        logic               burst;
        logic [1:0]         wlog;
        logic [1:0]         lsel;
        logic [WAIT_W-1:0]  waits;
        logic [SH_W-1:0]    setup;
        logic [SH_W-1:0]    hold;
    } brom_cfg_t;

    // log2 of bus width in bytes; code 3 behaves as 32-bit
    function automatic logic [1:0] width_log(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    // clamp the burst-length code to the largest legal one for the width
    function automatic logic [1:0] clamp_len(input logic [2:0] code, input logic [1:0] wl);
        logic [2:0] maxc;
        maxc = 3'(OFF_W - 2) - {1'b0, wl};
        if (code > maxc) return maxc[1:0];
        return code[1:0];
    endfunction

endpackage

// File: rtl/brom_addr_gen.sv
module brom_addr_gen
    import brom_pkg::*;
(
    input  logic [BROM_AW-1:0] start_addr,
    input  logic [1:0]         wlog,
    input  logic [BEAT_W-1:0]  beat,
    output logic [BROM_AW-1:0] addr,
    output logic [OFF_W-1:0]   off
);
    localparam int unsigned SUM_W = OFF_W + 3;

    logic [OFF_W-1:0] unit_mask;
    logic [OFF_W-1:0] off0;
    logic [SUM_W-1:0] step;
    logic [SUM_W-1:0] sum;

    always_comb begin
        unit_mask = ~((OFF_W'(1) << wlog) - OFF_W'(1));
        off0      = start_addr[OFF_W-1:0] & unit_mask;
        step      = SUM_W'(beat) << wlog;
        sum       = SUM_W'(off0) + step;
        off       = sum[OFF_W-1:0];
        addr      = {start_addr[BROM_AW-1:OFF_W], off};
    end

endmodule

// File: rtl/brom_line_pack.sv
module brom_line_pack
    import brom_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      capture,
    input  logic [OFF_W-1:0]          off,
    input  logic [1:0]                wlog,
    input  logic [BROM_DW-1:0]        rdata,
    output logic [LINE_BYTES*8-1:0]   line
);
    logic [LINE_BYTES-1:0] hits;

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        localparam logic [OFF_W-1:0] BI = OFF_W'(b);
        logic [LANE_W-1:0] lane;
        logic [7:0]        byte_q;

        always_comb begin
            case (wlog)
                2'd0:    lane = '0;
                2'd1:    lane = LANE_W'(BI[0]);
                default: lane = BI[LANE_W-1:0];
            endcase
        end

        assign hits[b] = capture && ((BI >> wlog) == (off >> wlog));

        always_ff @(posedge clk) begin
            if (rst)          byte_q <= '0;
            else if (hits[b]) byte_q <= rdata[lane*8 +: 8];
        end

        assign line[b*8 +: 8] = byte_q;
    end

    // one captured beat fills exactly one bus unit of the line
    assert_unit_fill_R10: assert property (@(posedge clk) disable iff (rst)
        capture |-> ($countones(hits) == (1 << wlog)));

endmodule

// File: rtl/brom_seq.sv
module brom_seq
    import brom_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  brom_cfg_t          req_cfg,
    input  logic               bus_rdy,
    output brom_state_e        st_o,
    output logic [BEAT_W-1:0]  beat_o,
    output logic               capture_o,
    output logic [BROM_AW-1:0] start_addr_o,
    output logic [BROM_DW-1:0] wdata_o,
    output logic               write_o,
    output logic               burst_o,
    output logic [1:0]         wlog_o
);
    brom_state_e       st;
    brom_cfg_t         cfg_q;
    logic [CNT_W-1:0]  cnt;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] bcnt;

    logic [BEAT_W-1:0] beats_total;
    logic [BEAT_W-1:0] burst_len;
    logic [CNT_W-1:0]  first_len;
    logic [CNT_W-1:0]  next_len;
    logic              last_cnt;
    logic              rdy_ok;
    logic              beat_done;
    logic              burst_end;
    logic              all_done;

    always_comb begin
        beats_total = cfg_q.write ? BEAT_W'(1) : BEAT_W'(LINE_BYTES >> cfg_q.wlog);
        burst_len   = cfg_q.burst ? BEAT_W'(4 << cfg_q.lsel) : BEAT_W'(1);
        first_len   = CNT_W'(cfg_q.waits) + CNT_W'(1);
        next_len    = (cfg_q.waits == '0) ? CNT_W'(3) : first_len;
        last_cnt    = (cnt == CNT_W'(1));
        rdy_ok      = (cfg_q.waits == '0) || bus_rdy;
        beat_done   = (st == ST_STRB) && last_cnt && rdy_ok;
        burst_end   = (beat == beats_total - BEAT_W'(1)) || (bcnt == burst_len - BEAT_W'(1));
        all_done    = (beat == beats_total);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cfg_q <= '0;
            cnt   <= '0;
            beat  <= '0;
            bcnt  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cfg_q <= req_cfg;
                        beat  <= '0;
                        bcnt  <= '0;
                        if (req_cfg.setup != '0) begin
                            st  <= ST_SETUP;
                            cnt <= CNT_W'(req_cfg.setup);
                        end else begin
                            st  <= ST_STRB;
                            cnt <= CNT_W'(req_cfg.waits) + CNT_W'(1);
                        end
                    end
                end
                ST_SETUP: begin
                    if (last_cnt) begin
                        st  <= ST_STRB;
                        cnt <= first_len;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_STRB: begin
                    if (!last_cnt) begin
                        cnt <= cnt - CNT_W'(1);
                    end else if (rdy_ok) begin
                        beat <= beat + BEAT_W'(1);
                        if (burst_end) begin
                            bcnt <= '0;
                            if (cfg_q.hold != '0) begin
                                st  <= ST_HOLD;
                                cnt <= CNT_W'(cfg_q.hold);
                            end else if (beat == beats_total - BEAT_W'(1)) begin
                                st <= ST_DONE;
                            end else begin
                                st <= ST_GAP;
                            end
                        end else begin
                            bcnt <= bcnt + BEAT_W'(1);
                            cnt  <= next_len;
                        end
                    end
                end
                ST_HOLD: begin
                    if (last_cnt) st <= all_done ? ST_DONE : ST_GAP;
                    else          cnt <= cnt - CNT_W'(1);
                end
                ST_GAP: begin
                    if (cfg_q.setup != '0) begin
                        st  <= ST_SETUP;
                        cnt <= CNT_W'(cfg_q.setup);
                    end else begin
                        st  <= ST_STRB;
                        cnt <= first_len;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign st_o         = st;
    assign beat_o       = beat;
    assign capture_o    = beat_done;
    assign start_addr_o = cfg_q.addr;
    assign wdata_o      = cfg_q.wdata;
    assign write_o      = cfg_q.write;
    assign burst_o      = cfg_q.burst;
    assign wlog_o       = cfg_q.wlog;

    // with zero waits the final strobe cycle always ends the beat
    assert_no_rdy_wait0_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STRB && cnt == CNT_W'(1) && cfg_q.waits == '0) |=> (beat != $past(beat)));

    // a read line completes only after every beat was fetched
    assert_beats_complete_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE && !cfg_q.write) |-> (beat == beats_total));

endmodule

// File: rtl/brom_ctrl.sv
module brom_ctrl
    import brom_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [31:0]             req_addr,
    input  logic [31:0]             req_wdata,
    input  logic [2:0]              cfg_type,
    input  logic [1:0]              cfg_width,
    input  logic [2:0]              cfg_len,
    input  logic [3:0]              cfg_wait,
    input  logic [1:0]              cfg_setup,
    input  logic [1:0]              cfg_hold,
    output logic [31:0]             bus_addr,
    output logic                    bus_cs_n,
    output logic                    bus_rd_n,
    output logic                    bus_we_n,
    output logic [31:0]             bus_wdata,
    input  logic                    bus_rdy,
    input  logic [31:0]             bus_rdata,
    output logic                    busy,
    output logic                    line_valid,
    output logic [255:0]            line_data,
    output logic                    wr_done
);
    brom_cfg_t          req_cfg;
    brom_state_e        st;
    logic [BEAT_W-1:0]  beat;
    logic               capture;
    logic [BROM_AW-1:0] start_addr;
    logic [BROM_DW-1:0] wdata_q;
    logic               is_write;
    logic               is_burst;
    logic [1:0]         wlog_q;
    logic [OFF_W-1:0]   off;
    logic [1:0]         wl_in;

    always_comb begin
        wl_in         = width_log(cfg_width);
        req_cfg.addr  = req_addr;
        req_cfg.wdata = req_wdata;
        req_cfg.write = req_write;
        req_cfg.burst = (cfg_type == IF_BURST) && !req_write;
        req_cfg.wlog  = wl_in;
        req_cfg.lsel  = clamp_len(cfg_len, wl_in);
        req_cfg.waits = cfg_wait;
        req_cfg.setup = cfg_setup;
        req_cfg.hold  = cfg_hold;
    end

    brom_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_cfg      (req_cfg),
        .bus_rdy      (bus_rdy),
        .st_o         (st),
        .beat_o       (beat),
        .capture_o    (capture),
        .start_addr_o (start_addr),
        .wdata_o      (wdata_q),
        .write_o      (is_write),
        .burst_o      (is_burst),
        .wlog_o       (wlog_q)
    );

    logic [BROM_AW-1:0] gen_addr;

    brom_addr_gen u_addr (
        .start_addr (start_addr),
        .wlog       (wlog_q),
        .beat       (beat),
        .addr       (gen_addr),
        .off        (off)
    );

    brom_line_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .capture (capture && !is_write),
        .off     (off),
        .wlog    (wlog_q),
        .rdata   (bus_rdata),
        .line    (line_data)
    );

    always_comb begin
        bus_addr   = is_write ? start_addr : gen_addr;
        bus_cs_n   = !(st == ST_SETUP || st == ST_STRB || st == ST_HOLD);
        bus_rd_n   = !(st == ST_STRB && !is_write);
        bus_we_n   = !(st == ST_STRB && is_write);
        bus_wdata  = wdata_q;
        busy       = (st != ST_IDLE);
        line_valid = (st == ST_DONE) && !is_write;
        wr_done    = (st == ST_DONE) && is_write;
    end

    assert_strobe_in_cs_R5: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n || !bus_we_n) |-> !bus_cs_n);

    assert_rd_we_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_we_n));

    assert_line_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        line_valid |=> !line_valid);

    assert_block_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (bus_addr[BROM_AW-1:OFF_W] == $past(bus_addr[BROM_AW-1:OFF_W])));

    // address steps under a held-low strobe only in burst mode
    assert_addr_step_burst_R2: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n && $past(!bus_rd_n) && bus_addr != $past(bus_addr)) |-> is_burst);

endmodule

// File: tb/brom_ctrl_tb_top.sv
module brom_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [2:0]   cfg_type = '0;
    logic [1:0]   cfg_width = '0;
    logic [2:0]   cfg_len = '0;
    logic [3:0]   cfg_wait = '0;
    logic [1:0]   cfg_setup = '0;
    logic [1:0]   cfg_hold = '0;
    logic [31:0]  bus_addr;
    logic         bus_cs_n, bus_rd_n, bus_we_n;
    logic [31:0]  bus_wdata;
    logic         bus_rdy = 1'b1;
    logic [31:0]  bus_rdata;
    logic         busy, line_valid, wr_done;
    logic [255:0] line_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] romb(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign bus_rdata = {romb(bus_addr + 32'd3), romb(bus_addr + 32'd2),
                        romb(bus_addr + 32'd1), romb(bus_addr)};

    brom_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_type(cfg_type),
        .cfg_width(cfg_width), .cfg_len(cfg_len), .cfg_wait(cfg_wait),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .bus_addr(bus_addr),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
        .bus_wdata(bus_wdata), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
        .busy(busy), .line_valid(line_valid), .line_data(line_data),
        .wr_done(wr_done)
    );

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(bus_cs_n && bus_rd_n && bus_we_n, "R1 strobes idle", {bus_cs_n, bus_rd_n, bus_we_n}, 7);
        chk(!busy && !line_valid && !wr_done, "R1 flags low", {busy, line_valid, wr_done}, 0);
    endtask

    // read a line; stall>0 holds ready low up to that cycle, rdy_low_all holds it low always
    task automatic do_read(input string tag, input logic [2:0] ty, input logic [1:0] wc,
                           input logic [2:0] lc, input int w, input int su, input int ho,
                           input logic [31:0] a, input int stall, input bit rdy_low_all,
                           input bit poke);
        int wl, wb, nb, lsz, sb, tcyc, cycles, beats, rises, badaddr, badbyte, k, maxc, lcc;
        bit prev_rd_low, done;
        logic [31:0] prev_addr, base, off0;
        wl = (wc == 2'd0) ? 0 : (wc == 2'd1) ? 1 : 2;
        wb = 1 << wl;
        nb = 32 / wb;
        if (ty == 3'b010) begin
            maxc = 3 - wl;
            lcc  = (int'(lc) > maxc) ? maxc : int'(lc);
            lsz  = 4 << lcc;
        end else lsz = 1;
        sb   = nb / lsz;
        tcyc = sb * (su + 1 + w + (lsz - 1) * ((w == 0) ? 3 : 1 + w) + ho) + sb - 1;
        base = {a[31:5], 5'd0};
        off0 = {27'd0, a[4:0]} & ~(32'(wb) - 32'd1);

        @(negedge clk);
        cfg_type = ty; cfg_width = wc; cfg_len = lc; cfg_wait = 4'(w);
        cfg_setup = 2'(su); cfg_hold = 2'(ho); req_addr = a; req_write = 1'b0;
        req_valid = 1'b1;
        bus_rdy = (rdy_low_all || stall > 0) ? 1'b0 : 1'b1;
        cycles = 0; beats = 0; rises = 0; badaddr = 0; k = 0; done = 0;
        prev_rd_low = 0; prev_addr = '0;
        while (!done && k < 5000) begin
            @(negedge clk);
            k++;
            if (k == 1) req_valid = 1'b0;
            if (poke && k == 3) begin req_valid = 1'b1; req_addr = a ^ 32'h0000_1000; end
            if (poke && k == 4) req_valid = 1'b0;
            if (line_valid) done = 1;
            else if (busy) cycles++;
            if (!bus_rd_n && (!prev_rd_low || bus_addr != prev_addr)) begin
                if (bus_addr != base + ((off0 + 32'(beats * wb)) & 32'h1F)) badaddr++;
                beats++;
            end
            if (bus_rd_n && prev_rd_low) rises++;
            prev_rd_low = !bus_rd_n;
            prev_addr = bus_addr;
            if (stall > 0 && k == stall - 1)
                chk(beats == 1, {tag, " R8 beat held while ready low"}, beats, 1);
            if (rdy_low_all) bus_rdy = 1'b0;
            else             bus_rdy = (k >= stall) ? 1'b1 : 1'b0;
        end
        chk(done, {tag, " R9 line completes"}, done, 1);
        if (stall > 0)
            chk(cycles > tcyc, {tag, " R8 ready stall lengthens"}, cycles, tcyc);
        else
            chk(cycles == tcyc, {tag, " R6 R7 busy cycles"}, cycles, tcyc);
        chk(beats == nb, {tag, " R4 beat count"}, beats, nb);
        chk(badaddr == 0, {tag, " R4 wrap addresses"}, badaddr, 0);
        chk(rises == sb, {tag, " R5 R3 R2 strobe rises"}, rises, sb);
        badbyte = 0;
        for (int b = 0; b < 32; b++)
            if (line_data[b*8 +: 8] !== romb(base + 32'(b))) badbyte++;
        chk(badbyte == 0, {tag, " R10 line bytes"}, badbyte, 0);
        @(negedge clk);
        chk(!line_valid, {tag, " R10 single pulse"}, line_valid, 0);
        if (poke) begin
            @(negedge clk);
            @(negedge clk);
            chk(!busy && bus_cs_n, {tag, " R9 request while busy ignored"}, busy, 0);
        end
        bus_rdy = 1'b1;
    endtask

    task automatic do_write(input string tag, input logic [2:0] ty, input int w,
                            input int su, input int ho, input logic [31:0] a,
                            input logic [31:0] d);
        int cycles, we_cyc, cs_cyc, rd_cyc, bad, k, tcyc;
        bit done;
        tcyc = su + 1 + w + ho;
        @(negedge clk);
        cfg_type = ty; cfg_width = 2'd2; cfg_len = 3'd1; cfg_wait = 4'(w);
        cfg_setup = 2'(su); cfg_hold = 2'(ho); req_addr = a; req_wdata = d;
        req_write = 1'b1; req_valid = 1'b1; bus_rdy = 1'b1;
        cycles = 0; we_cyc = 0; cs_cyc = 0; rd_cyc = 0; bad = 0; k = 0; done = 0;
        while (!done && k < 1000) begin
            @(negedge clk);
            k++;
            if (k == 1) begin req_valid = 1'b0; req_write = 1'b0; end
            if (wr_done) done = 1;
            else if (busy) cycles++;
            if (!bus_we_n) begin
                we_cyc++;
                if (bus_addr != a || bus_wdata != d) bad++;
            end
            if (!bus_cs_n) cs_cyc++;
            if (!bus_rd_n) rd_cyc++;
        end
        chk(done, {tag, " R11 write done pulse"}, done, 1);
        chk(cycles == tcyc, {tag, " R11 write cycles"}, cycles, tcyc);
        chk(we_cyc == 1 + w, {tag, " R11 write strobe width"}, we_cyc, 1 + w);
        chk(cs_cyc == tcyc, {tag, " R11 R7 select width"}, cs_cyc, tcyc);
        chk(rd_cyc == 0, {tag, " R11 no read strobe"}, rd_cyc, 0);
        chk(bad == 0, {tag, " R11 address and data"}, bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        test_reset();
        // R2 R4 R6: 8-bit, 32-beat burst, zero waits, unaligned start
        do_read("b8_len32",  3'b010, 2'd0, 3'd3, 0, 0, 0, 32'h1234_5673, 0, 0, 0);
        // R7 R9: 16-bit, 4-beat bursts, setup/hold, stray request
        do_read("b16_len4",  3'b010, 2'd1, 3'd0, 1, 1, 1, 32'h0000_A04B, 0, 0, 1);
        // R3: 32-bit with codes above its limit clamp to 8 beats
        do_read("b32_clamp3", 3'b010, 2'd2, 3'd3, 0, 0, 0, 32'h0008_001C, 0, 0, 0);
        do_read("b32_clamp6", 3'b010, 2'd3, 3'd6, 2, 0, 1, 32'h0008_0105, 0, 0, 0);
        // R3: 16-bit code 3 clamps to 16 beats
        do_read("b16_clamp", 3'b010, 2'd1, 3'd3, 0, 2, 0, 32'h0003_3336, 0, 0, 0);
        // R2: non-burst type makes separate accesses
        do_read("sram32",    3'b000, 2'd2, 3'd1, 1, 1, 2, 32'h0000_0F14, 0, 0, 0);
        // R8: ready ignored with zero waits
        do_read("rdy_w0",    3'b010, 2'd1, 3'd1, 0, 0, 0, 32'h0040_0012, 0, 1, 0);
        // R8: ready low stalls a beat when waits are set
        do_read("rdy_stall", 3'b010, 2'd2, 3'd1, 2, 1, 0, 32'h0050_0008, 12, 0, 0);
        // R11: writes are single accesses in either interface type
        do_write("wr_burst", 3'b010, 1, 1, 1, 32'h0000_2224, 32'hCAFE_F00D);
        do_write("wr_sram",  3'b001, 0, 0, 0, 32'h0000_3330, 32'h1357_9BDF);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule